// File: doc/BRIEF.md
# Dual-Bank Floating-Point Register File

This block holds the floating-point register state for a processor core. The state is two banks of sixteen 32-bit words. The foreground bank is the one that ordinary operands and results use. The background bank is reached only through paired transfers. A 32-bit mode word selects how the file is used. One bit picks the bank, one bit picks the transfer width for moves, and one bit picks single or double precision. When the bank bit changes, the two banks exchange their contents outright. After such a change, index 0 in the foreground always names the word that was just brought forward.

An execution pipeline uses the file through five ports. The read port delivers operands: a single word, or an even-aligned 64-bit pair when double precision is on. The write port takes results in the same two shapes. The move port copies one word or one pair from register to register. The conversion port truncates a stored value to a 32-bit integer. The mode port writes the mode word or toggles its bank and size bits. Operand reads and result writes in double-precision mode must name an even register. When one names an odd register, the block raises an illegal-operation flag and suppresses the access.

Top module: `fprf_top`

## Requirements
- R1: After reset the mode word reads 0 (bank 0 in front, single precision, 32-bit moves), and every word of both banks reads 0.
- R2: With the precision bit (bit 19) clear, a foreground write stores `wr_data[31:0]` at `wr_idx`. A foreground read of that index returns `{32'h0, word}` on `rd_data` one cycle after `rd_en`.
- R3: A mode write that changes bit 21 exchanges the whole contents of the two banks. A mode write that leaves bit 21 unchanged leaves every register as it was.
- R4: `ctl_tog_bank` inverts bit 21 only, and this inversion also exchanges the banks. `ctl_tog_size` inverts bit 20 only. Each toggle applies on top of any value written to the mode word in the same cycle.
- R5: With bit 19 set, a foreground access at an even index n covers words n and n+1 of the foreground bank. Word n carries bits 63:32 and word n+1 carries bits 31:0.
- R6: With bit 19 set, a foreground read or write at an odd index raises `ill` for one cycle, starting in the cycle after the request. That request changes no register and leaves `rd_data` unchanged.
- R7: A pair transfer (`rd_xpair`/`wr_xpair`) at index n reaches bank n[0]. It covers register n with bit 0 cleared (upper 32 bits) and the register above it (lower 32 bits), whatever the state of bit 19.
- R8: With bit 20 set, a move copies two words, from pair location src to pair location dst, using the R7 mapping for both. With bit 20 clear, a move copies the single foreground word src to the foreground word dst.
- R9: A conversion truncates toward zero and returns the result on `cv_data` one cycle after the request. With bit 19 clear, the operand is the single foreground word at `cv_idx`. With bit 19 set, the operand is the foreground pair at `cv_idx` with bit 0 cleared. A NaN or infinite operand, and any value whose magnitude is 2^31 or more, returns 32'h8000_0000.
- R10: When a register write and a bank exchange happen in the same cycle, the write lands in the bank that was in front before the exchange.
- R11: When a move and a write target the same word in the same cycle, the write's value is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Write the mode word |
| ctl_wdata | input | 32 | New mode word value |
| ctl_tog_bank | input | 1 | Invert the bank bit (21) |
| ctl_tog_size | input | 1 | Invert the move-size bit (20) |
| ctl_q | output | 32 | Current mode word |
| rd_en | input | 1 | Read request |
| rd_xpair | input | 1 | 1: pair transfer using the R7 mapping; 0: foreground access |
| rd_idx | input | 4 | Read register index |
| rd_data | output | 64 | Registered read data |
| wr_en | input | 1 | Write request |
| wr_xpair | input | 1 | 1: pair transfer using the R7 mapping; 0: foreground access |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 64 | Write data (pair: 63:32 upper word) |
| mv_en | input | 1 | Register-to-register move |
| mv_src | input | 4 | Move source index |
| mv_dst | input | 4 | Move destination index |
| cv_en | input | 1 | Truncating conversion request |
| cv_idx | input | 4 | Conversion operand index |
| cv_data | output | 32 | Registered conversion result |
| ill | output | 1 | Illegal register specifier seen in the previous cycle |

## Verification
The bench checks the whole file by reading every index as a pair transfer, which covers all 32 words in both banks. It does this after each kind of stimulus. As a result, a write that lands in the wrong bank or the wrong half of a pair shows up, even when the foreground view still looks right. Index patterns run through all sixteen values in both access shapes. Each index is paired with distinct data, so the checks can tell the even/odd and bank-select decoding apart.

The mode word gets these stimuli:
- writes that change the bank bit
- writes that leave the bank bit unchanged
- toggles, including a toggle in the same cycle as a register write

Together these separate an exchange from an ordinary update. The conversion sweep covers every single-precision exponent and a band of double-precision exponents around the integer range, each with both signs and three mantissa shapes. This exercises truncation, underflow to zero, the overflow limit and the NaN/infinity sentinel in both precisions.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

  localparam logic [31:0] CVT_SENTINEL = 32'h8000_0000;

  // Truncate an IEEE single (dbl=0, v[31:0]) or double (dbl=1) toward zero.
  function automatic logic [31:0] f2i(input logic dbl, input logic [63:0] v);
    logic        sgn;
    logic        top_exp;
    int          e;
    logic [52:0] man;
    logic [31:0] mag;
    if (dbl) begin
      sgn     = v[63];
      top_exp = &v[62:52];
      e       = int'(v[62:52]) - 1023;
      man     = {1'b1, v[51:0]};
    end else begin
      sgn     = v[31];
      top_exp = &v[30:23];
      e       = int'(v[30:23]) - 127;
      man     = {1'b1, v[22:0], 29'd0};
    end
    if (top_exp || e >= 31) return CVT_SENTINEL;
    if (e < 0) return 32'd0;
    mag = 32'(man >> (52 - e));
    return sgn ? (32'd0 - mag) : mag;
  endfunction

endpackage

// File: rtl/fprf_ctl.sv
module fprf_ctl #(
  parameter int CW       = 32,
  parameter int BANK_BIT = 21,
  parameter int SIZE_BIT = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  input  logic          tog_bank,
  input  logic          tog_size,
  output logic [CW-1:0] q,
  output logic          swap
);

  localparam logic [CW-1:0] ONE       = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] BANK_MASK = ONE << BANK_BIT;
  localparam logic [CW-1:0] SIZE_MASK = ONE << SIZE_BIT;

  logic [CW-1:0] base, nxt;

  always_comb begin
    base = we ? wdata : q;
    nxt  = base;
    nxt[BANK_BIT] = base[BANK_BIT] ^ tog_bank;
    nxt[SIZE_BIT] = base[SIZE_BIT] ^ tog_size;
  end

  assign swap = nxt[BANK_BIT] ^ q[BANK_BIT];

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  // R1: mode word is cleared by reset
  a_r1_ctl_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (q == '0));
  // R4: bank toggle alone flips only the bank bit
  a_r4_bank_toggle: assert property (@(posedge clk) disable iff (rst)
    (tog_bank && !tog_size && !we) |=> (q == ($past(q) ^ BANK_MASK)));
  // R4: size toggle alone flips only the size bit
  a_r4_size_toggle: assert property (@(posedge clk) disable iff (rst)
    (tog_size && !tog_bank && !we) |=> (q == ($past(q) ^ SIZE_MASK)));

endmodule

// File: rtl/fprf_store.sv
module fprf_store #(
  parameter int NREG  = 16,
  parameter int DW    = 32,
  parameter int NLANE = 4,
  localparam int NW   = 2 * NREG,
  localparam int AW   = $clog2(NW)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NLANE-1:0]           ln_en,
  input  logic [NLANE-1:0][AW-1:0]   ln_addr,
  input  logic [NLANE-1:0][DW-1:0]   ln_data,
  input  logic                       swap,
  output logic [NW-1:0][DW-1:0]      words
);

  logic [NW-1:0][DW-1:0] mem, wrt, nxt;

  // Lanes apply in index order, so a higher lane wins on a shared address.
  always_comb begin
    wrt = mem;
    for (int l = 0; l < NLANE; l++) begin
      if (ln_en[l]) wrt[ln_addr[l]] = ln_data[l];
    end
  end

  // Bank exchange after the writes: writes target the pre-swap front bank.
  generate
    for (genvar i = 0; i < NW; i++) begin : g_word
      assign nxt[i] = swap ? wrt[(i + NREG) % NW] : wrt[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) mem <= '0;
    else     mem <= nxt;
  end

  assign words = mem;

  // R3: an exchange with no writes moves bank contents across
  a_r3_exchange: assert property (@(posedge clk) disable iff (rst)
    (swap && !(|ln_en)) |=> ((mem[0] == $past(mem[NREG])) && (mem[NREG] == $past(mem[0]))));
  // R3: no exchange and no writes keeps every word
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!swap && !(|ln_en)) |=> $stable(mem));

endmodule

// File: rtl/fprf_cvt.sv
module fprf_cvt #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          dbl,
  input  logic [2*DW-1:0] opnd,
  output logic [DW-1:0] res
);
  import fprf_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)     res <= '0;
    else if (en) res <= DW'(f2i(dbl, 64'(opnd)));
  end

  // R9: NaN or infinity gives the sentinel in double mode
  a_r9_dbl_sentinel: assert property (@(posedge clk) disable iff (rst)
    (en && dbl && (&opnd[62:52])) |=> (res == DW'(CVT_SENTINEL)));
  // R9: same in single mode
  a_r9_sgl_sentinel: assert property (@(posedge clk) disable iff (rst)
    (en && !dbl && (&opnd[30:23])) |=> (res == DW'(CVT_SENTINEL)));

endmodule

// File: rtl/fprf_top.sv
module fprf_top #(
  parameter int NREG     = 16,
  parameter int DW       = 32,
  parameter int CW       = 32,
  parameter int BANK_BIT = 21,
  parameter int SIZE_BIT = 20,
  parameter int PREC_BIT = 19,
  localparam int IW      = $clog2(NREG),
  localparam int NW      = 2 * NREG,
  localparam int AW      = IW + 1,
  localparam int NLANE   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctl_we,
  input  logic [CW-1:0]   ctl_wdata,
  input  logic            ctl_tog_bank,
  input  logic            ctl_tog_size,
  output logic [CW-1:0]   ctl_q,
  input  logic            rd_en,
  input  logic            rd_xpair,
  input  logic [IW-1:0]   rd_idx,
  output logic [2*DW-1:0] rd_data,
  input  logic            wr_en,
  input  logic            wr_xpair,
  input  logic [IW-1:0]   wr_idx,
  input  logic [2*DW-1:0] wr_data,
  input  logic            mv_en,
  input  logic [IW-1:0]   mv_src,
  input  logic [IW-1:0]   mv_dst,
  input  logic            cv_en,
  input  logic [IW-1:0]   cv_idx,
  output logic [DW-1:0]   cv_data,
  output logic            ill
);

  localparam logic [AW-1:0] A1 = {{(AW-1){1'b0}}, 1'b1};

  // Pair mapping: index bit 0 picks the bank, remaining bits the even register.
  function automatic logic [AW-1:0] xmap(input logic [IW-1:0] n);
    return {n[0], n[IW-1:1], 1'b0};
  endfunction

  function automatic logic [AW-1:0] fg(input logic [IW-1:0] n);
    return {1'b0, n};
  endfunction

  function automatic logic [AW-1:0] fg_even(input logic [IW-1:0] n);
    return {1'b0, n[IW-1:1], 1'b0};
  endfunction

  logic                      swap;
  logic                      pr, sz;
  logic [NW-1:0][DW-1:0]     words;
  logic [NLANE-1:0]          ln_en;
  logic [NLANE-1:0][AW-1:0]  ln_addr;
  logic [NLANE-1:0][DW-1:0]  ln_data;
  logic                      rd_ill, wr_ill;
  logic [2*DW-1:0]           rd_nxt;
  logic [2*DW-1:0]           cv_opnd;

  fprf_ctl #(.CW(CW), .BANK_BIT(BANK_BIT), .SIZE_BIT(SIZE_BIT)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .we       (ctl_we),
    .wdata    (ctl_wdata),
    .tog_bank (ctl_tog_bank),
    .tog_size (ctl_tog_size),
    .q        (ctl_q),
    .swap     (swap)
  );

  assign pr = ctl_q[PREC_BIT];
  assign sz = ctl_q[SIZE_BIT];

  // Lanes 0/1: move; lanes 2/3: write (write has priority).
  always_comb begin
    ln_en   = '0;
    ln_addr = '0;
    ln_data = '0;
    rd_ill  = rd_en && !rd_xpair && pr && rd_idx[0];
    wr_ill  = wr_en && !wr_xpair && pr && wr_idx[0];

    if (mv_en) begin
      if (sz) begin
        ln_en[0]   = 1'b1;
        ln_addr[0] = xmap(mv_dst);
        ln_data[0] = words[xmap(mv_src)];
        ln_en[1]   = 1'b1;
        ln_addr[1] = xmap(mv_dst) | A1;
        ln_data[1] = words[xmap(mv_src) | A1];
      end else begin
        ln_en[0]   = 1'b1;
        ln_addr[0] = fg(mv_dst);
        ln_data[0] = words[fg(mv_src)];
      end
    end

    if (wr_en && !wr_ill) begin
      if (wr_xpair || pr) begin
        ln_en[2]   = 1'b1;
        ln_addr[2] = wr_xpair ? xmap(wr_idx) : fg_even(wr_idx);
        ln_data[2] = wr_data[2*DW-1:DW];
        ln_en[3]   = 1'b1;
        ln_addr[3] = (wr_xpair ? xmap(wr_idx) : fg_even(wr_idx)) | A1;
        ln_data[3] = wr_data[DW-1:0];
      end else begin
        ln_en[2]   = 1'b1;
        ln_addr[2] = fg(wr_idx);
        ln_data[2] = wr_data[DW-1:0];
      end
    end

    if (rd_xpair)
      rd_nxt = {words[xmap(rd_idx)], words[xmap(rd_idx) | A1]};
    else if (pr)
      rd_nxt = {words[fg_even(rd_idx)], words[fg_even(rd_idx) | A1]};
    else
      rd_nxt = {{DW{1'b0}}, words[fg(rd_idx)]};

    if (pr)
      cv_opnd = {words[fg_even(cv_idx)], words[fg_even(cv_idx) | A1]};
    else
      cv_opnd = {{DW{1'b0}}, words[fg(cv_idx)]};
  end

  fprf_store #(.NREG(NREG), .DW(DW), .NLANE(NLANE)) u_store (
    .clk     (clk),
    .rst     (rst),
    .ln_en   (ln_en),
    .ln_addr (ln_addr),
    .ln_data (ln_data),
    .swap    (swap),
    .words   (words)
  );

  fprf_cvt #(.DW(DW)) u_cvt (
    .clk  (clk),
    .rst  (rst),
    .en   (cv_en),
    .dbl  (pr),
    .opnd (cv_opnd),
    .res  (cv_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      ill     <= 1'b0;
    end else begin
      ill <= rd_ill || wr_ill;
      if (rd_en && !rd_ill) rd_data <= rd_nxt;
    end
  end

  // R6: the flag only follows a cycle in double-precision mode
  a_r6_flag_in_double: assert property (@(posedge clk) disable iff (rst)
    ill |-> $past(ctl_q[PREC_BIT]));
  // R6: odd write in double mode leaves the register file untouched
  a_r6_no_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_xpair && ctl_q[PREC_BIT] && wr_idx[0] && !mv_en && !ctl_we && !ctl_tog_bank)
    |=> $stable(words));
  // R6: odd read in double mode leaves the read data unchanged
  a_r6_read_held: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_xpair && ctl_q[PREC_BIT] && rd_idx[0]) |=> $stable(rd_data));

endmodule

// File: tb/fprf_top_tb.sv
module fprf_top_tb;

  localparam int NW = 32;

  logic        clk = 1'b0;
  logic        rst;
  logic        ctl_we, ctl_tog_bank, ctl_tog_size;
  logic [31:0] ctl_wdata, ctl_q;
  logic        rd_en, rd_xpair, wr_en, wr_xpair, mv_en, cv_en, ill;
  logic [3:0]  rd_idx, wr_idx, mv_src, mv_dst, cv_idx;
  logic [63:0] rd_data, wr_data;
  logic [31:0] cv_data;

  always #5 clk = ~clk;

  fprf_top u_dut (
    .clk(clk), .rst(rst),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_tog_bank(ctl_tog_bank),
    .ctl_tog_size(ctl_tog_size), .ctl_q(ctl_q),
    .rd_en(rd_en), .rd_xpair(rd_xpair), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_xpair(wr_xpair), .wr_idx(wr_idx), .wr_data(wr_data),
    .mv_en(mv_en), .mv_src(mv_src), .mv_dst(mv_dst),
    .cv_en(cv_en), .cv_idx(cv_idx), .cv_data(cv_data), .ill(ill)
  );

  logic [31:0] mdl [NW];
  logic [31:0] mctl;
  logic [63:0] e_rd;
  logic [31:0] e_cv;
  logic        e_ill;
  int          nvec = 0;
  int          nbad = 0;
  bit          done = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] xm(logic [3:0] n);
    return {n[0], n[3:1], 1'b0};
  endfunction

  function automatic logic [31:0] ref_trunc(logic dbl, logic [63:0] v);
    real r;
    if (dbl) begin
      if (v[62:52] == 11'h7FF) return 32'h8000_0000;
      r = $bitstoreal(v);
    end else begin
      if (v[30:23] == 8'hFF) return 32'h8000_0000;
      if (v[30:23] == 8'h00) return 32'h0;
      r = $bitstoreal({v[31], 11'(v[30:23]) + 11'd896, v[22:0], 29'd0});
    end
    if (r >= 2147483648.0 || r <= -2147483649.0) return 32'h8000_0000;
    return 32'($rtoi(r));
  endfunction

  // One clock: compute expectations from the requirements, update model.
  task automatic tick();
    logic [31:0] nx [NW];
    logic [31:0] base, nctl;
    logic        pr, sz, rill;
    pr   = mctl[19];
    sz   = mctl[20];
    rill = rd_en && !rd_xpair && pr && rd_idx[0];
    e_ill = rill || (wr_en && !wr_xpair && pr && wr_idx[0]);
    if (rd_en && !rill) begin
      if (rd_xpair)  e_rd = {mdl[xm(rd_idx)], mdl[xm(rd_idx) | 5'd1]};
      else if (pr)   e_rd = {mdl[{1'b0, rd_idx}], mdl[{1'b0, rd_idx | 4'd1}]};
      else           e_rd = {32'h0, mdl[{1'b0, rd_idx}]};
    end
    if (cv_en) begin
      if (pr) e_cv = ref_trunc(1'b1, {mdl[{1'b0, cv_idx & 4'hE}], mdl[{1'b0, cv_idx | 4'h1}]});
      else    e_cv = ref_trunc(1'b0, {32'h0, mdl[{1'b0, cv_idx}]});
    end
    for (int i = 0; i < NW; i++) nx[i] = mdl[i];
    if (mv_en) begin
      if (sz) begin
        nx[xm(mv_dst)]         = mdl[xm(mv_src)];
        nx[xm(mv_dst) | 5'd1]  = mdl[xm(mv_src) | 5'd1];
      end else begin
        nx[{1'b0, mv_dst}] = mdl[{1'b0, mv_src}];
      end
    end
    if (wr_en) begin
      if (wr_xpair) begin
        nx[xm(wr_idx)]        = wr_data[63:32];
        nx[xm(wr_idx) | 5'd1] = wr_data[31:0];
      end else if (pr) begin
        if (!wr_idx[0]) begin
          nx[{1'b0, wr_idx}]        = wr_data[63:32];
          nx[{1'b0, wr_idx | 4'd1}] = wr_data[31:0];
        end
      end else begin
        nx[{1'b0, wr_idx}] = wr_data[31:0];
      end
    end
    base = ctl_we ? ctl_wdata : mctl;
    nctl = base ^ (32'(ctl_tog_bank) << 21) ^ (32'(ctl_tog_size) << 20);
    for (int i = 0; i < NW; i++)
      mdl[i] = (nctl[21] != mctl[21]) ? nx[(i + 16) % NW] : nx[i];
    mctl = nctl;
    @(negedge clk);
    rd_en = 0; wr_en = 0; mv_en = 0; cv_en = 0;
    ctl_we = 0; ctl_tog_bank = 0; ctl_tog_size = 0;
    rd_xpair = 0; wr_xpair = 0;
  endtask

  task automatic set_ctl(logic [31:0] v);
    ctl_we = 1; ctl_wdata = v; tick();
  endtask

  task automatic wr(logic xp, logic [3:0] i, logic [63:0] d);
    wr_en = 1; wr_xpair = xp; wr_idx = i; wr_data = d; tick();
  endtask

  task automatic rd(string tag, logic xp, logic [3:0] i);
    rd_en = 1; rd_xpair = xp; rd_idx = i; tick();
    chk(tag, rd_data, e_rd);
  endtask

  // Pair reads at every index cover all words of both banks.
  task automatic scan_all(string tag);
    for (int i = 0; i < 16; i++) rd(tag, 1'b1, 4'(i));
  endtask

  task automatic scan_fg(string tag);
    for (int i = 0; i < 16; i++) rd(tag, 1'b0, 4'(i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    rst = 1;
    ctl_we = 0; ctl_wdata = 0; ctl_tog_bank = 0; ctl_tog_size = 0;
    rd_en = 0; rd_xpair = 0; rd_idx = 0;
    wr_en = 0; wr_xpair = 0; wr_idx = 0; wr_data = 0;
    mv_en = 0; mv_src = 0; mv_dst = 0; cv_en = 0; cv_idx = 0;
    for (int i = 0; i < NW; i++) mdl[i] = 32'h0;
    mctl = 32'h0; e_rd = 64'h0; e_cv = 32'h0; e_ill = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1: reset state
    chk("R1 ctl", {32'h0, ctl_q}, 64'h0);
    scan_fg("R1 fg zero");
    scan_all("R1 pair zero");

    // R2: single-word writes and reads in the foreground
    for (int i = 0; i < 16; i++)
      wr(1'b0, 4'(i), {32'hDEAD_BEEF, 32'h4100_0000 + 32'(i) * 32'h0101_0301});
    scan_fg("R2 single");
    scan_all("R2 both banks");

    // R7: pair transfers reach both banks by index bit 0
    for (int i = 0; i < 16; i++)
      wr(1'b1, 4'(i), {32'hA000_0000 | 32'(i << 8), 32'h0B00_0000 | 32'(i * 7)});
    scan_all("R7 pair map");
    scan_fg("R7 fg view");

    // R3: bank bit change exchanges banks; other changes do not
    set_ctl(32'h0020_00A5);
    chk("R3 ctl", {32'h0, ctl_q}, {32'h0, mctl});
    scan_fg("R3 swapped fg");
    scan_all("R3 swapped");
    set_ctl(32'h0020_1100);
    scan_all("R3 no swap");

    // R4: toggles
    ctl_tog_bank = 1; tick();
    chk("R4 bank toggle", {32'h0, ctl_q}, {32'h0, mctl});
    scan_all("R4 bank toggle swap");
    ctl_tog_size = 1; tick();
    chk("R4 size toggle", {32'h0, ctl_q}, {32'h0, mctl});
    scan_all("R4 size toggle no swap");
    ctl_tog_size = 1; ctl_we = 1; ctl_wdata = 32'h0000_0003; tick();
    chk("R4 toggle over write", {32'h0, ctl_q}, {32'h0, mctl});
    scan_all("R4 toggle over write");

    // R5: double precision pairs in the foreground
    set_ctl(32'h0008_0000);
    wr(1'b0, 4'd4, 64'h1122_3344_5566_7788);
    wr(1'b0, 4'd10, 64'h99AA_BBCC_DDEE_FF00);
    for (int i = 0; i < 16; i += 2) rd("R5 pair read", 1'b0, 4'(i));
    scan_all("R5 halves");

    // R6: odd specifiers in double mode
    rd("R6 prime", 1'b0, 4'd4);
    rd_en = 1; rd_idx = 4'd5; tick();
    chk("R6 ill on read", {63'h0, ill}, 64'h1);
    chk("R6 rd held", rd_data, e_rd);
    wr(1'b0, 4'd7, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R6 ill on write", {63'h0, ill}, {63'h0, e_ill});
    scan_all("R6 no change");
    chk("R6 ill clears", {63'h0, ill}, 64'h0);

    // R8: moves, pair and single width
    set_ctl(32'h0010_0000);
    mv_en = 1; mv_src = 4'd3; mv_dst = 4'd8; tick();
    scan_all("R8 pair move");
    mv_en = 1; mv_src = 4'd12; mv_dst = 4'd1; tick();
    scan_all("R8 pair move to bg");
    set_ctl(32'h0);
    mv_en = 1; mv_src = 4'd2; mv_dst = 4'd9; tick();
    scan_all("R8 single move");

    // R10: write and bank exchange in the same cycle
    ctl_tog_bank = 1; wr_en = 1; wr_idx = 4'd3; wr_data = {32'h0, 32'hCAFE_F00D}; tick();
    scan_all("R10 write pre-swap bank");
    scan_fg("R10 fg view");

    // R11: write wins over move on the same word
    set_ctl(32'h0);
    mv_en = 1; mv_src = 4'd5; mv_dst = 4'd6;
    wr_en = 1; wr_idx = 4'd6; wr_data = {32'h0, 32'h1357_9BDF}; tick();
    scan_all("R11 write wins");

    // R9: single-precision truncation sweep
    for (int ex = 0; ex < 256; ex++)
      for (int s = 0; s < 2; s++)
        for (int m = 0; m < 3; m++) begin
          logic [22:0] man;
          man = (m == 0) ? 23'h0 : (m == 1) ? 23'h40_0001 : 23'h7F_FFFF;
          wr(1'b0, 4'd7, {32'h0, 1'(s), 8'(ex), man});
          cv_en = 1; cv_idx = 4'd7; tick();
          chk("R9 single trunc", {32'h0, cv_data}, {32'h0, e_cv});
        end

    // R9: double-precision truncation sweep (odd index uses even pair)
    set_ctl(32'h0008_0000);
    for (int k = 0; k < 64; k++)
      for (int s = 0; s < 2; s++)
        for (int m = 0; m < 3; m++) begin
          logic [51:0] man;
          logic [10:0] ex;
          ex  = (k == 62) ? 11'h000 : (k == 63) ? 11'h7FF : 11'(1000 + k);
          man = (m == 0) ? 52'h0 : (m == 1) ? 52'h8_0000_0000_0001 : 52'hF_FFFF_FFFF_FFFF;
          wr(1'b0, 4'd6, {1'(s), ex, man});
          cv_en = 1; cv_idx = 4'(6 + (k & 1)); tick();
          chk("R9 double trunc", {32'h0, cv_data}, {32'h0, e_cv});
        end

    // R9: explicit NaN in both precisions
    wr(1'b0, 4'd2, 64'h7FF8_0000_0000_0000);
    cv_en = 1; cv_idx = 4'd2; tick();
    chk("R9 double NaN", {32'h0, cv_data}, 64'h8000_0000);
    set_ctl(32'h0);
    wr(1'b0, 4'd2, {32'h0, 32'h7FC0_0000});
    cv_en = 1; cv_idx = 4'd2; tick();
    chk("R9 single NaN", {32'h0, cv_data}, 64'h8000_0000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule